// File: doc/BRIEF.md
# Priority Pin Function Resolver

This block decides which signal owns each of four multi-function pins. Software configures it through a small word-addressed register bus that reaches five 32-bit pin-control registers. A sixth register holds strap values; it is captured from an input bus while reset is held and cannot be changed by software afterwards.

Every pin has a ranked list of up to five signal levels, level 0 being the strongest. Each level is enabled by an OR of terms, and each term is an AND of field comparisons taken from anywhere in the register bank. A field comparison takes a shifted, masked slice of a register and tests it for equality or inequality with a constant. The strongest level whose expression holds wins. The last level of each pin is the fallback and is always available. For each pin the block drives a one-hot select vector and the binary index of the winning level. Both are combinational from the register state, so a write changes them in the same cycle in which it is accepted.

Register offsets: 0x00 reset-control, 0x04 mux A, 0x08 mux B, 0x0C mux C, 0x10 mux D, 0x14 strap (read-only). Pin p uses `pinSel[p*5 +: 5]`, where bit k means level k, and `pinLvl[p*3 +: 3]`.

Top module: `pin_priority_mux`

## Requirements
- R1: While `rstN` is low on a rising edge, all five control registers and `busRdata` become zero and the strap register loads `strapIn`. Every pin then resolves to its fallback level, apart from strap-enabled levels.
- R2: A write (`busWr` high) to offset 0x00, 0x04, 0x08, 0x0C or 0x10 stores `busWdata`. A read (`busRd` high) returns the register on `busRdata` one cycle later, and `busRdata` holds that value until the next read.
- R3: Writes to the strap offset 0x14 and to unmapped or unaligned offsets have no effect. Reads of 0x14 return the captured strap, and reads of any unmapped or unaligned offset return zero.
- R4: For every pin, the select field has exactly one bit set, and that bit's position equals the binary index on `pinLvl`.
- R5: Pin 0 uses three levels. Level 0 needs reset-control bit 3 = 1, mux A bit 15 = 1 and mux C bit 31 = 0. Level 1 needs the same first two bits with mux C bit 31 = 1. Level 2 is the fallback.
- R6: Pin 1 uses three levels, and mux C [5:4] is a video width field (00 off, 01 18-bit, 10 24-bit, 11 30-bit). Level 0 needs the field nonzero and mux B bit 17 = 1. Level 1 needs only mux B bit 17 = 1, so it wins only when the field is 00. Level 2 is the fallback.
- R7: Pin 2 uses three levels. Level 0 needs mux A bit 25 = 1. Level 1 needs mux D bit 12 = 1 OR strap bit 19 = 0, and it loses to level 0. Level 2 is the fallback.
- R8: Pin 3 uses five levels: level 0 needs mux D bit 0 = 1; level 1 needs mux C [5:4] = 11 and mux B bit 22 = 1; level 2 needs mux B bit 22 = 1; level 3 needs strap bit 6 = 0; level 4 is the fallback.
- R9: Pin outputs change only as a result of a register write or a reset. After a write, they show the new resolution in the cycle that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapIn | input | 32 | Strap values captured during reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| pinSel | output | 20 | One-hot level select, 5 bits per pin |
| pinLvl | output | 12 | Winning level index, 3 bits per pin |

## Verification
Read data is registered. The bench queues each expected read value when it raises the read strobe, and compares it at the falling edge after the sampling rising edge, which is exactly one cycle later. Pin outputs are combinational from the registers. A write that is accepted on a rising edge is therefore checked at the falling edge of the same cycle, against a level computed by the bench's own expression model from its shadow registers. The strap-dependent levels are exercised by two resets with different strap values.

// File: rtl/pinres_pkg.sv
package pinres_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NCTL   = 5;
  localparam int NREG   = NCTL + 1;
  localparam int NPINS  = 4;
  localparam int NLVL   = 5;
  localparam int NTERM  = 2;
  localparam int NDESC  = 3;
  localparam int LVL_W  = $clog2(NLVL);
  localparam int IDX_W  = $clog2(NREG);
  localparam int FLD_W  = 4;

  localparam int RI_RST = 0, RI_MA = 1, RI_MB = 2, RI_MC = 3, RI_MD = 4, RI_ST = 5;

  typedef enum logic {CMP_EQ = 1'b0, CMP_NE = 1'b1} cmpOp_e;

  typedef struct packed {
    logic             used;
    cmpOp_e           op;
    logic [IDX_W-1:0] regIdx;
    logic [4:0]       lsb;
    logic [FLD_W-1:0] fmask;
    logic [FLD_W-1:0] val;
  } desc_t;

  typedef struct packed {
    logic [NCTL-1:0]  wrOne;
    logic             rdGo;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } stb_t;

  function automatic desc_t mk(int ri, int lsb, int fm, int v, cmpOp_e op);
    desc_t d;
    d.used   = 1'b1;
    d.op     = op;
    d.regIdx = IDX_W'(ri);
    d.lsb    = 5'(lsb);
    d.fmask  = FLD_W'(fm);
    d.val    = FLD_W'(v);
    return d;
  endfunction

  function automatic int levelCount(int pin);
    return (pin == 3) ? 5 : 3;
  endfunction

  // Expression table: key = {pin, level, term, descriptor slot}
  function automatic desc_t descAt(int pin, int lvl, int term, int idx);
    logic [7:0] key;
    key = {pin[1:0], lvl[2:0], term[0], idx[1:0]};
    case (key)
      {2'd0, 3'd0, 1'd0, 2'd0}: return mk(RI_RST, 3, 1, 1, CMP_EQ);
      {2'd0, 3'd0, 1'd0, 2'd1}: return mk(RI_MA, 15, 1, 1, CMP_EQ);
      {2'd0, 3'd0, 1'd0, 2'd2}: return mk(RI_MC, 31, 1, 0, CMP_EQ);
      {2'd0, 3'd1, 1'd0, 2'd0}: return mk(RI_RST, 3, 1, 1, CMP_EQ);
      {2'd0, 3'd1, 1'd0, 2'd1}: return mk(RI_MA, 15, 1, 1, CMP_EQ);
      {2'd0, 3'd1, 1'd0, 2'd2}: return mk(RI_MC, 31, 1, 1, CMP_EQ);
      {2'd1, 3'd0, 1'd0, 2'd0}: return mk(RI_MC, 4, 3, 0, CMP_NE);
      {2'd1, 3'd0, 1'd0, 2'd1}: return mk(RI_MB, 17, 1, 1, CMP_EQ);
      {2'd1, 3'd1, 1'd0, 2'd0}: return mk(RI_MB, 17, 1, 1, CMP_EQ);
      {2'd2, 3'd0, 1'd0, 2'd0}: return mk(RI_MA, 25, 1, 1, CMP_EQ);
      {2'd2, 3'd1, 1'd0, 2'd0}: return mk(RI_MD, 12, 1, 1, CMP_EQ);
      {2'd2, 3'd1, 1'd1, 2'd0}: return mk(RI_ST, 19, 1, 0, CMP_EQ);
      {2'd3, 3'd0, 1'd0, 2'd0}: return mk(RI_MD, 0, 1, 1, CMP_EQ);
      {2'd3, 3'd1, 1'd0, 2'd0}: return mk(RI_MC, 4, 3, 3, CMP_EQ);
      {2'd3, 3'd1, 1'd0, 2'd1}: return mk(RI_MB, 22, 1, 1, CMP_EQ);
      {2'd3, 3'd2, 1'd0, 2'd0}: return mk(RI_MB, 22, 1, 1, CMP_EQ);
      {2'd3, 3'd3, 1'd0, 2'd0}: return mk(RI_ST, 6, 1, 0, CMP_EQ);
      default:                  return desc_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/pinres_ctrl.sv
module pinres_ctrl
  import pinres_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busWr,
  input  logic          busRd,
  input  logic [AW-1:0] busAddr,
  output stb_t          stb
);
  always_comb begin
    stb = '0;
    stb.rdGo = busRd;
    for (int i = 0; i < NCTL; i++) begin
      if (busAddr == AW'(i * 4)) stb.wrOne[i] = busWr;
    end
    for (int i = 0; i < NREG; i++) begin
      if (busAddr == AW'(i * 4)) begin
        stb.rdHit = 1'b1;
        stb.rdIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pinres_regs.sv
module pinres_regs
  import pinres_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DW-1:0]           strapIn,
  input  logic [DW-1:0]           busWdata,
  input  stb_t                    stb,
  output logic [NREG-1:0][DW-1:0] regVals,
  output logic [DW-1:0]           busRdata
);
  logic [NCTL-1:0][DW-1:0] ctlQ;
  logic [DW-1:0]           strapQ;
  logic [DW-1:0]           rdQ;

  assign regVals  = {strapQ, ctlQ};
  assign busRdata = rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ   <= '0;
      strapQ <= strapIn;
      rdQ    <= '0;
    end else begin
      for (int i = 0; i < NCTL; i++) begin
        if (stb.wrOne[i]) ctlQ[i] <= busWdata;
      end
      if (stb.rdGo) rdQ <= stb.rdHit ? regVals[stb.rdIdx] : '0;
    end
  end
endmodule

// File: rtl/pinres_eval.sv
module pinres_eval
  import pinres_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [NREG-1:0][DW-1:0] regVals,
  output logic [NPINS*NLVL-1:0]   pinSel,
  output logic [NPINS*LVL_W-1:0]  pinLvl
);
  logic [NPINS-1:0][NLVL-1:0] lvlTrue;

  for (genvar p = 0; p < NPINS; p++) begin : gPin
    for (genvar l = 0; l < NLVL; l++) begin : gLvl
      logic [NTERM-1:0] termHit;
      for (genvar t = 0; t < NTERM; t++) begin : gTerm
        logic [NDESC-1:0] dOk;
        logic [NDESC-1:0] dUsed;
        for (genvar k = 0; k < NDESC; k++) begin : gDesc
          localparam desc_t D = descAt(p, l, t, k);
          logic [FLD_W-1:0] fld;
          assign fld      = FLD_W'(regVals[D.regIdx] >> D.lsb) & D.fmask;
          assign dUsed[k] = D.used;
          assign dOk[k]   = !D.used ||
                            ((D.op == CMP_EQ) ? (fld == D.val) : (fld != D.val));
        end
        assign termHit[t] = (|dUsed) && (&dOk);
      end
      localparam int CNT = levelCount(p);
      assign lvlTrue[p][l] = (l == CNT - 1) ? 1'b1 : ((l < CNT) && (|termHit));
    end
  end

  always_comb begin
    logic found;
    pinSel = '0;
    pinLvl = '0;
    for (int p = 0; p < NPINS; p++) begin
      found = 1'b0;
      for (int l = 0; l < NLVL; l++) begin
        if (!found && lvlTrue[p][l]) begin
          pinSel[p*NLVL + l]        = 1'b1;
          pinLvl[p*LVL_W +: LVL_W]  = LVL_W'(l);
          found                     = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pin_priority_mux.sv
module pin_priority_mux
  import pinres_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DW-1:0]          strapIn,
  input  logic                   busWr,
  input  logic                   busRd,
  input  logic [AW-1:0]          busAddr,
  input  logic [DW-1:0]          busWdata,
  output logic [DW-1:0]          busRdata,
  output logic [NPINS*NLVL-1:0]  pinSel,
  output logic [NPINS*LVL_W-1:0] pinLvl
);
  stb_t                    stb;
  logic [NREG-1:0][DW-1:0] regVals;

  pinres_ctrl #(.AW(AW)) uCtrl (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .stb(stb)
  );

  pinres_regs #(.DW(DW)) uRegs (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .busWdata(busWdata),
    .stb(stb), .regVals(regVals), .busRdata(busRdata)
  );

  pinres_eval #(.DW(DW)) uEval (
    .regVals(regVals), .pinSel(pinSel), .pinLvl(pinLvl)
  );
endmodule

// File: rtl/pin_priority_mux_chk.sv
module pin_priority_mux_chk
  import pinres_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [DW-1:0]          strapIn,
  input logic                   busWr,
  input logic                   busRd,
  input logic [AW-1:0]          busAddr,
  input logic [DW-1:0]          busRdata,
  input logic [NPINS*NLVL-1:0]  pinSel,
  input logic [NPINS*LVL_W-1:0] pinLvl
);
  localparam logic [AW-1:0] STRAP_OFS = AW'(NCTL * 4);
  logic [DW-1:0] capStrap;
  logic          unmapped;

  always_ff @(posedge clk) if (!rstN) capStrap <= strapIn;

  assign unmapped = (busAddr[1:0] != 2'b00) || (int'(busAddr) >= NREG * 4);

  assert_reset_rdata_R1: assert property (@(posedge clk)
    !rstN |=> busRdata == '0);

  assert_strap_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr == STRAP_OFS |=> busRdata == capStrap);

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    busRd && unmapped |=> busRdata == '0);

  assert_pins_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> $stable(pinSel) && $stable(pinLvl));

  for (genvar p = 0; p < NPINS; p++) begin : gChk
    assert_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
      $countones(pinSel[p*NLVL +: NLVL]) == 1 &&
      pinSel[p*NLVL + int'(pinLvl[p*LVL_W +: LVL_W])]);
  end
endmodule

bind pin_priority_mux pin_priority_mux_chk #(.AW(AW), .DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .strapIn(strapIn), .busWr(busWr), .busRd(busRd),
  .busAddr(busAddr), .busRdata(busRdata), .pinSel(pinSel), .pinLvl(pinLvl)
);

// File: tb/tb_pin_priority_mux.sv
`timescale 1ns/1ps
module tb_pin_priority_mux;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] strapIn = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [19:0] pinSel;
  logic [11:0] pinLvl;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] sh [5];
  logic [31:0] shStrap = '0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdDly = 1'b0;

  always #4 clk = ~clk;

  pin_priority_mux dut (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinSel(pinSel), .pinLvl(pinLvl)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRd(logic [7:0] a);
    if (a[1:0] != 0) return 32'h0;
    if (a < 8'h14) return sh[a >> 2];
    if (a == 8'h14) return shStrap;
    return 32'h0;
  endfunction

  function automatic int expLvl(int p);
    case (p)
      0: begin
        bit a = sh[0][3] && sh[1][15];
        if (a && !sh[3][31]) return 0;
        if (a && sh[3][31]) return 1;
        return 2;
      end
      1: begin
        if (sh[3][5:4] != 0 && sh[2][17]) return 0;
        if (sh[2][17]) return 1;
        return 2;
      end
      2: begin
        if (sh[1][25]) return 0;
        if (sh[4][12] || !shStrap[19]) return 1;
        return 2;
      end
      default: begin
        if (sh[4][0]) return 0;
        if (sh[3][5:4] == 2'b11 && sh[2][22]) return 1;
        if (sh[2][22]) return 2;
        if (!shStrap[6]) return 3;
        return 4;
      end
    endcase
  endfunction

  // Monitor: pops the expected read value one cycle after the read strobe
  always @(posedge clk) rdDly <= busRd && rstN;
  always @(negedge clk) begin
    if (rdDly) begin
      if (expQ.size() == 0) chk(0, "R2 unexpected read data", busRdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(busRdata === e, t, busRdata, e);
      end
    end
  end

  task automatic doReset(logic [31:0] sv);
    @(negedge clk);
    rstN = 0; strapIn = sv;
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int i = 0; i < 5; i++) sh[i] = '0;
    shStrap = sv;
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 0;
    if (a[1:0] == 0 && a < 8'h14) sh[a >> 2] = d;
  endtask

  task automatic rdReg(logic [7:0] a, string tag);
    busRd = 1; busAddr = a;
    expQ.push_back(expRd(a));
    tagQ.push_back(tag);
    @(negedge clk);
    busRd = 0;
  endtask

  task automatic checkPins(string tag);
    for (int p = 0; p < 4; p++) begin
      int e = expLvl(p);
      logic [4:0] es = 5'(1 << e);
      chk(pinSel[p*5 +: 5] === es, $sformatf("R4 %s pin%0d sel", tag, p),
          32'(pinSel[p*5 +: 5]), 32'(es));
      chk(pinLvl[p*3 +: 3] === 3'(e), $sformatf("%s pin%0d lvl", tag, p),
          32'(pinLvl[p*3 +: 3]), 32'(e));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset with strap bit19 = 1, bit6 = 1
    doReset(32'h0008_0040);
    chk(busRdata === 32'h0, "R1 rdata after reset", busRdata, 32'h0);
    checkPins("R1 R9 reset");
    for (int i = 0; i < 5; i++) rdReg(8'(i * 4), "R1 ctrl reg zero");
    rdReg(8'h14, "R3 strap capture");

    // R2 readback
    wrReg(8'h00, 32'hA5A5_0001); wrReg(8'h04, 32'h1234_5678);
    wrReg(8'h08, 32'hFFFF_0000); wrReg(8'h0C, 32'h0F0F_F0F0);
    wrReg(8'h10, 32'h8000_0001);
    for (int i = 0; i < 5; i++) rdReg(8'(i * 4), "R2 readback");
    checkPins("R9 after writes");

    // R3 ignored writes
    for (int i = 0; i < 5; i++) wrReg(8'(i * 4), 32'h0);
    wrReg(8'h14, 32'h0);
    checkPins("R3 R7 strap write ignored");
    rdReg(8'h14, "R3 strap unchanged");
    wrReg(8'h18, 32'hFFFF_FFFF);
    wrReg(8'h02, 32'hFFFF_FFFF);
    wrReg(8'hFC, 32'hFFFF_FFFF);
    checkPins("R3 unmapped write ignored");
    for (int i = 0; i < 5; i++) rdReg(8'(i * 4), "R3 no alias");
    rdReg(8'h18, "R3 unmapped read");
    rdReg(8'h05, "R3 unaligned read");

    // R5 pin 0
    wrReg(8'h00, 32'h8); wrReg(8'h04, 32'h8000); checkPins("R5 lvl0");
    wrReg(8'h0C, 32'h8000_0000); checkPins("R5 lvl1");
    wrReg(8'h00, 32'h0); checkPins("R5 fallback");
    // R6 pin 1
    wrReg(8'h0C, 32'h0); wrReg(8'h08, 32'h0002_0000); checkPins("R6 field00");
    wrReg(8'h0C, 32'h10); checkPins("R6 18b");
    wrReg(8'h0C, 32'h20); checkPins("R6 24b");
    wrReg(8'h0C, 32'h30); checkPins("R6 30b");
    // R7 pin 2
    wrReg(8'h10, 32'h1000); checkPins("R7 lvl1");
    wrReg(8'h04, 32'h0200_0000); checkPins("R7 lvl0 wins");
    wrReg(8'h04, 32'h0); wrReg(8'h10, 32'h0); checkPins("R7 fallback");
    // R8 pin 3
    wrReg(8'h08, 32'h0040_0000); checkPins("R8 lvl1");
    wrReg(8'h0C, 32'h20); checkPins("R8 lvl2");
    wrReg(8'h10, 32'h1); checkPins("R8 lvl0");
    wrReg(8'h10, 32'h0); wrReg(8'h08, 32'h0); checkPins("R8 fallback");

    // Random register contents
    for (int n = 0; n < 150; n++) begin
      wrReg(8'($urandom_range(0, 4) * 4), $urandom);
      checkPins("R5 R6 R7 R8 random");
    end

    // Second reset: strap bit19 = 0, bit6 = 0
    doReset(32'h0);
    checkPins("R1 R7 R8 strap low");
    rdReg(8'h14, "R3 strap capture low");
    for (int n = 0; n < 150; n++) begin
      wrReg(8'($urandom_range(0, 4) * 4), $urandom);
      if (n % 7 == 0) rdReg(8'($urandom_range(0, 6) * 4), "R2 R3 random read");
      checkPins("R5 R6 R7 R8 random strap low");
    end

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2 all reads answered", 32'(expQ.size()), 32'h0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule